// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block is the interrupt core of a serial port. It turns the receive and transmit FIFO occupancy counts into a live status word, compared against two trigger levels that software can program. Every cycle it folds those status conditions, together with single-cycle error and event pulses from the receiver and transmitter, into a sticky status register. The unit raises one level-sensitive interrupt line whenever a sticky bit is also enabled in the mask.

Software reaches the unit through a simple register port. The port has a write strobe, a 3-bit register select and write data. A separate read select returns read data in the same cycle. The mask is changed only through a set-bits code and a clear-bits code. The sticky register is cleared by writing ones. The FIFOs, the serializer and the address decoder live outside this block.

Top module: `uart_irq_unit`

## Requirements
- R1: Live status bits (select code 4) are: bit1 when the receive count is 0, bit2 when it equals RX_DEPTH, bit0 when it is at or above the receive trigger level; bit3 when the transmit count is 0, bit4 when it equals TX_DEPTH.
- R2: Live status bit13 is set when the transmit count is at or above the transmit trigger level; bit10 mirrors rx_busy and bit11 mirrors tx_busy; every other live bit reads zero.
- R3: On each clock edge, live bits [4:0] are ORed into the same bits of the sticky register (select code 3), and the transmit-trigger condition is ORed into sticky bit10; a sticky bit stays set after its condition goes away.
- R4: A one-cycle pulse sets a sticky bit on the next edge: ev_rx_ovr bit5, ev_frame_err bit6, ev_parity_err bit7, ev_rx_timeout bit8, ev_modem bit9, ev_tx_ovf bit12.
- R5: A write with select code 0 ORs wr_data[12:0] into the 13-bit mask.
- R6: A write with select code 1 clears every mask bit written as 1.
- R7: A write with select code 2 leaves the mask unchanged; a read with code 2 returns the mask; reads with codes 0, 1 and 7 return zero.
- R8: A write with select code 3 clears exactly the sticky bits written as 1, unless a condition sets them again in that cycle.
- R9: When an event pulse and a clearing write hit the same sticky bit in the same cycle, the bit ends up set.
- R10: irq is high exactly when some bit is set in both the mask and the sticky register, and it follows register changes with no extra cycle.
- R11: While rst_n is low, the mask and sticky register read zero and both trigger levels read TRIG_RST (32 by default).
- R12: Writes with select code 5 (receive) and code 6 (transmit) load the trigger levels from the low count-width bits of wr_data. Reads with the same codes return them, and the new level takes effect in the live compare at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | REG_W | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | REG_W | Read data, combinational from rd_sel |
| rx_count | input | RX_CW | Receive FIFO occupancy |
| tx_count | input | TX_CW | Transmit FIFO occupancy |
| rx_busy | input | 1 | Receiver active |
| tx_busy | input | 1 | Transmitter active |
| ev_rx_ovr | input | 1 | Receive overrun pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_modem | input | 1 | Modem status change pulse |
| ev_tx_ovf | input | 1 | Transmit overflow pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the unit with its default parameters: 32-bit registers, both depths 64 (7-bit counts) and a reset trigger of 32. With these values the full flags are reached by driving a count of 64. The reset trigger sits in the middle of the count range, and writing 0x1FF to a trigger register shows the truncation to 7 bits. Counts are driven directly, so the bench can move any status condition in one cycle. It can also hold the counts away from both empty and trigger, so that a clear of the sticky register is not undone by the next edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int IRQ_W  = 13;
    localparam int LIVE_W = 14;
    localparam int N_EV   = 6;

    localparam int B_RX_TRIG     = 0;
    localparam int B_RX_EMPTY    = 1;
    localparam int B_RX_FULL     = 2;
    localparam int B_TX_EMPTY    = 3;
    localparam int B_TX_FULL     = 4;
    localparam int B_OVR         = 5;
    localparam int B_FRAME       = 6;
    localparam int B_PARITY      = 7;
    localparam int B_TMO         = 8;
    localparam int B_MODEM       = 9;
    localparam int B_TXTRIG_IRQ  = 10;
    localparam int B_RX_BUSY     = 10;
    localparam int B_TX_BUSY     = 11;
    localparam int B_TXOVF       = 12;
    localparam int B_TXTRIG_LIVE = 13;

    typedef enum logic [2:0] {
        SEL_MASK_SET  = 3'd0,
        SEL_MASK_CLR  = 3'd1,
        SEL_MASK_VIEW = 3'd2,
        SEL_STICKY    = 3'd3,
        SEL_LIVE      = 3'd4,
        SEL_RX_TRIG   = 3'd5,
        SEL_TX_TRIG   = 3'd6,
        SEL_NONE      = 3'd7
    } reg_sel_e;

    // Sticky bit position of event input i (order of the event vector)
    function automatic int ev_pos(input int i);
        case (i)
            0:       return B_OVR;
            1:       return B_FRAME;
            2:       return B_PARITY;
            3:       return B_TMO;
            4:       return B_MODEM;
            default: return B_TXOVF;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_live_flags.sv
module uart_irq_live_flags
    import uart_irq_pkg::*;
#(
    parameter int RX_DEPTH = 64,
    parameter int TX_DEPTH = 64,
    parameter int RX_CW    = 7,
    parameter int TX_CW    = 7
)(
    input  logic [RX_CW-1:0]  rx_count,
    input  logic [TX_CW-1:0]  tx_count,
    input  logic [RX_CW-1:0]  rx_trig,
    input  logic [TX_CW-1:0]  tx_trig,
    input  logic              rx_busy,
    input  logic              tx_busy,
    output logic [LIVE_W-1:0] live,
    output logic              tx_trig_hit
);
    localparam logic [RX_CW-1:0] RX_FULL_CNT = RX_CW'(RX_DEPTH);
    localparam logic [TX_CW-1:0] TX_FULL_CNT = TX_CW'(TX_DEPTH);

    always_comb begin
        tx_trig_hit         = (tx_count >= tx_trig);
        live                = '0;
        live[B_RX_TRIG]     = (rx_count >= rx_trig);
        live[B_RX_EMPTY]    = (rx_count == '0);
        live[B_RX_FULL]     = (rx_count == RX_FULL_CNT);
        live[B_TX_EMPTY]    = (tx_count == '0);
        live[B_TX_FULL]     = (tx_count == TX_FULL_CNT);
        live[B_RX_BUSY]     = rx_busy;
        live[B_TX_BUSY]     = tx_busy;
        live[B_TXTRIG_LIVE] = tx_trig_hit;
    end
endmodule

// File: rtl/uart_irq_trig_reg.sv
module uart_irq_trig_reg #(
    parameter int W       = 7,
    parameter int RST_VAL = 32
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] level
);
    typedef struct packed {
        logic [W-1:0] level;
    } trig_state_t;

    trig_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.level = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= W'(RST_VAL);
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.level;
endmodule

// File: rtl/uart_irq_mask_reg.sv
module uart_irq_mask_reg
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [IRQ_W-1:0] wbits,
    output logic [IRQ_W-1:0] mask
);
    typedef struct packed {
        logic [IRQ_W-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_stb) begin
            st_d.mask = st_q.mask | wbits;
        end
        if (clr_stb) begin
            st_d.mask = st_d.mask & ~wbits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask = st_q.mask;
endmodule

// File: rtl/uart_irq_sticky_reg.sv
module uart_irq_sticky_reg
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       live_low,
    input  logic             tx_trig_hit,
    input  logic [N_EV-1:0]  ev,
    input  logic             clr_stb,
    input  logic [IRQ_W-1:0] wbits,
    output logic [IRQ_W-1:0] sticky
);
    typedef struct packed {
        logic [IRQ_W-1:0] bits;
    } sticky_state_t;

    sticky_state_t    st_d, st_q;
    logic [IRQ_W-1:0] set_vec;
    logic [IRQ_W-1:0] clr_vec;

    always_comb begin
        set_vec               = '0;
        set_vec[4:0]          = live_low;
        set_vec[B_TXTRIG_IRQ] = tx_trig_hit;
        for (int i = 0; i < N_EV; i++) begin
            if (ev[i]) begin
                set_vec[ev_pos(i)] = 1'b1;
            end
        end
        clr_vec = clr_stb ? wbits : '0;
        // setting conditions are applied after the clear so they win
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sticky = st_q.bits;
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
    import uart_irq_pkg::*;
#(
    parameter  int REG_W    = 32,
    parameter  int RX_DEPTH = 64,
    parameter  int TX_DEPTH = 64,
    parameter  int TRIG_RST = 32,
    localparam int RX_CW    = $clog2(RX_DEPTH + 1),
    localparam int TX_CW    = $clog2(TX_DEPTH + 1)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [2:0]       rd_sel,
    output logic [REG_W-1:0] rd_data,
    input  logic [RX_CW-1:0] rx_count,
    input  logic [TX_CW-1:0] tx_count,
    input  logic             rx_busy,
    input  logic             tx_busy,
    input  logic             ev_rx_ovr,
    input  logic             ev_frame_err,
    input  logic             ev_parity_err,
    input  logic             ev_rx_timeout,
    input  logic             ev_modem,
    input  logic             ev_tx_ovf,
    output logic             irq
);
    logic [RX_CW-1:0]  rx_trig;
    logic [TX_CW-1:0]  tx_trig;
    logic [LIVE_W-1:0] live;
    logic              tx_trig_hit;
    logic [IRQ_W-1:0]  mask_vec;
    logic [IRQ_W-1:0]  sticky_vec;
    logic [N_EV-1:0]   ev_vec;
    logic              wr_mset, wr_mclr, wr_sticky, wr_rxt, wr_txt;
    reg_sel_e          wsel, rsel;

    always_comb begin
        wsel      = reg_sel_e'(wr_sel);
        wr_mset   = wr_en && (wsel == SEL_MASK_SET);
        wr_mclr   = wr_en && (wsel == SEL_MASK_CLR);
        wr_sticky = wr_en && (wsel == SEL_STICKY);
        wr_rxt    = wr_en && (wsel == SEL_RX_TRIG);
        wr_txt    = wr_en && (wsel == SEL_TX_TRIG);
        ev_vec    = {ev_tx_ovf, ev_modem, ev_rx_timeout,
                     ev_parity_err, ev_frame_err, ev_rx_ovr};
    end

    uart_irq_trig_reg #(.W(RX_CW), .RST_VAL(TRIG_RST)) i_rx_trig (
        .clk(clk), .rst_n(rst_n), .load(wr_rxt),
        .load_val(wr_data[RX_CW-1:0]), .level(rx_trig)
    );

    uart_irq_trig_reg #(.W(TX_CW), .RST_VAL(TRIG_RST)) i_tx_trig (
        .clk(clk), .rst_n(rst_n), .load(wr_txt),
        .load_val(wr_data[TX_CW-1:0]), .level(tx_trig)
    );

    uart_irq_live_flags #(
        .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH), .RX_CW(RX_CW), .TX_CW(TX_CW)
    ) i_live (
        .rx_count(rx_count), .tx_count(tx_count),
        .rx_trig(rx_trig), .tx_trig(tx_trig),
        .rx_busy(rx_busy), .tx_busy(tx_busy),
        .live(live), .tx_trig_hit(tx_trig_hit)
    );

    uart_irq_mask_reg i_mask (
        .clk(clk), .rst_n(rst_n), .set_stb(wr_mset), .clr_stb(wr_mclr),
        .wbits(wr_data[IRQ_W-1:0]), .mask(mask_vec)
    );

    uart_irq_sticky_reg i_sticky (
        .clk(clk), .rst_n(rst_n), .live_low(live[4:0]),
        .tx_trig_hit(tx_trig_hit), .ev(ev_vec), .clr_stb(wr_sticky),
        .wbits(wr_data[IRQ_W-1:0]), .sticky(sticky_vec)
    );

    always_comb begin
        rsel    = reg_sel_e'(rd_sel);
        rd_data = '0;
        case (rsel)
            SEL_MASK_VIEW: rd_data[IRQ_W-1:0]  = mask_vec;
            SEL_STICKY:    rd_data[IRQ_W-1:0]  = sticky_vec;
            SEL_LIVE:      rd_data[LIVE_W-1:0] = live;
            SEL_RX_TRIG:   rd_data[RX_CW-1:0]  = rx_trig;
            SEL_TX_TRIG:   rd_data[TX_CW-1:0]  = tx_trig;
            default:       rd_data             = '0;
        endcase
        irq = |(mask_vec & sticky_vec);
    end
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
    import uart_irq_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int RX_CW = 7
)(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic [REG_W-1:0] wr_data,
    input logic [RX_CW-1:0] rx_count,
    input logic             ev_rx_ovr,
    input logic             ev_rx_timeout,
    input logic [IRQ_W-1:0] mask_q,
    input logic [IRQ_W-1:0] sticky_q,
    input logic             irq
);
    logic [IRQ_W-1:0] clr_bits;
    assign clr_bits = (wr_en && wr_sel == SEL_STICKY) ? wr_data[IRQ_W-1:0] : '0;

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        &((~$past(sticky_q & ~clr_bits)) | sticky_q));

    // R3
    empty_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |=> sticky_q[B_RX_EMPTY]);

    // R4
    overrun_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_ovr |=> sticky_q[B_OVR]);

    // R9
    event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_timeout && wr_en && wr_sel == SEL_STICKY && wr_data[B_TMO])
        |=> sticky_q[B_TMO]);

    // R7
    view_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_MASK_VIEW) |=> $stable(mask_q));

    // R6
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_MASK_CLR)
        |=> ((mask_q & $past(wr_data[IRQ_W-1:0])) == '0));

    // R10
    no_mask_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
endmodule

bind uart_irq_unit uart_irq_chk #(.REG_W(REG_W), .RX_CW(RX_CW)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rx_count(rx_count), .ev_rx_ovr(ev_rx_ovr),
    .ev_rx_timeout(ev_rx_timeout), .mask_q(mask_vec),
    .sticky_q(sticky_vec), .irq(irq)
);

// File: tb/test_uart_irq_unit.sv
module test_uart_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int REG_W = 32;
    localparam int CW    = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_sel = '0;
    logic [REG_W-1:0] wr_data = '0;
    logic [2:0]       rd_sel = '0;
    logic [REG_W-1:0] rd_data;
    logic [CW-1:0]    rx_count = '0;
    logic [CW-1:0]    tx_count = '0;
    logic             rx_busy = 1'b0, tx_busy = 1'b0;
    logic [5:0]       ev = '0;
    logic             irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    event  mon_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_unit i_uart_irq_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .rx_count(rx_count), .tx_count(tx_count),
        .rx_busy(rx_busy), .tx_busy(tx_busy),
        .ev_rx_ovr(ev[0]), .ev_frame_err(ev[1]), .ev_parity_err(ev[2]),
        .ev_rx_timeout(ev[3]), .ev_modem(ev[4]), .ev_tx_ovf(ev[5]),
        .irq(irq)
    );

    // monitor: pops expected items and compares with the design outputs
    initial begin
        forever begin
            @(mon_ev);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = it.is_irq ? {31'b0, irq} : rd_data;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_rd(input logic [2:0] sel, input logic [31:0] exp, input string tag);
        item_t it;
        rd_sel = sel;
        #1;
        it.is_irq = 1'b0; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        -> mon_ev;
        #1;
    endtask

    task automatic expect_irq(input bit exp, input string tag);
        item_t it;
        #1;
        it.is_irq = 1'b1; it.exp = {31'b0, exp}; it.tag = tag;
        sb.push_back(it);
        -> mon_ev;
        #1;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] v);
        ev = v;
        step();
        ev = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        expect_rd(3'd3, 32'h0, "R11 sticky in reset");
        expect_rd(3'd2, 32'h0, "R11 mask in reset");
        expect_rd(3'd5, 32'd32, "R11 rx trigger in reset");
        expect_rd(3'd6, 32'd32, "R11 tx trigger in reset");
        expect_irq(1'b0, "R11 irq in reset");
        // R1 both FIFOs empty
        expect_rd(3'd4, 32'h000A, "R1 live empty flags");
        rst_n = 1'b1;
        step();
        expect_rd(3'd3, 32'h000A, "R3 empty flags latched");
        rx_count = 7'd5; tx_count = 7'd5;
        expect_rd(3'd4, 32'h0000, "R1 live mid-level");
        step();
        expect_rd(3'd3, 32'h000A, "R3 sticky kept after condition gone");
        wr(3'd3, 32'hFFFF);
        expect_rd(3'd3, 32'h0000, "R8 clear all");
        rx_count = 7'd64; tx_count = 7'd64;
        expect_rd(3'd4, 32'h2015, "R1 R2 live full and trigger");
        step();
        expect_rd(3'd3, 32'h0415, "R3 sticky with tx trigger at bit10");
        rx_busy = 1'b1; tx_busy = 1'b1;
        expect_rd(3'd4, 32'h2C15, "R2 busy bits");
        rx_busy = 1'b0; tx_busy = 1'b0;
        rx_count = 7'd5; tx_count = 7'd5;
        wr(3'd3, 32'h0005);
        expect_rd(3'd3, 32'h0410, "R8 partial clear");
        wr(3'd3, 32'hFFFF);
        // R4 events
        pulse(6'b111111);
        expect_rd(3'd3, 32'h13E0, "R4 all events");
        wr(3'd3, 32'hFFFF);
        pulse(6'b000100);
        expect_rd(3'd3, 32'h0080, "R4 parity at bit7");
        wr(3'd3, 32'h0080);
        expect_rd(3'd3, 32'h0000, "R8 parity cleared");
        // mask
        wr(3'd0, 32'h0081);
        expect_rd(3'd2, 32'h0081, "R5 mask set");
        wr(3'd0, 32'h0100);
        expect_rd(3'd2, 32'h0181, "R5 mask OR");
        wr(3'd1, 32'h0001);
        expect_rd(3'd2, 32'h0180, "R6 mask clear");
        wr(3'd2, 32'h1FFF);
        expect_rd(3'd2, 32'h0180, "R7 view write ignored");
        expect_rd(3'd0, 32'h0, "R7 set code reads zero");
        expect_rd(3'd7, 32'h0, "R7 spare code reads zero");
        // irq
        expect_irq(1'b0, "R10 nothing pending");
        pulse(6'b000010);
        expect_irq(1'b0, "R10 unmasked frame bit");
        pulse(6'b001000);
        expect_irq(1'b1, "R10 timeout masked in");
        wr(3'd3, 32'h0100);
        expect_irq(1'b0, "R10 after clear");
        // R9 event and clear together
        ev = 6'b001000; wr_en = 1'b1; wr_sel = 3'd3; wr_data = 32'h0140;
        step();
        ev = '0; wr_en = 1'b0;
        expect_rd(3'd3, 32'h0100, "R9 event wins over clear");
        expect_irq(1'b1, "R9 irq stays");
        wr(3'd3, 32'hFFFF);
        // R12 triggers
        wr(3'd5, 32'd4);
        expect_rd(3'd5, 32'd4, "R12 rx trigger readback");
        expect_rd(3'd4, 32'h0001, "R12 rx trigger applied");
        wr(3'd6, 32'd6);
        expect_rd(3'd6, 32'd6, "R12 tx trigger readback");
        tx_count = 7'd6;
        expect_rd(3'd4, 32'h2001, "R12 tx trigger applied");
        step();
        expect_rd(3'd3, 32'h0401, "R3 trigger bits latched");
        wr(3'd6, 32'h1FF);
        expect_rd(3'd6, 32'h7F, "R12 trigger truncated");
        expect_rd(3'd4, 32'h0001, "R12 tx below new trigger");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule